// File: doc/BRIEF.md
# Bidirectional Printer Parallel Port

A CPU-facing parallel port for a printer-style peripheral. It holds an 8-bit data latch that either drives a three-state bus toward the device or steps aside so the bus can be sampled. It also provides four general control outputs, reports five device status inputs, and raises an interrupt when the device acknowledge line falls. The CPU reaches four register slots through a 2-bit address and active-low read and write strobes. Both strobes are sampled by the block clock. A write takes effect at the first clock edge that sees the write strobe low after it was high.

The bus direction can be set in two ways. The first is a bit in the control register. The second is a pattern slot that accepts one 8-bit code meaning "drive" and another meaning "listen". A read-active output follows the read strobe so that external transceivers can be turned around. The polarity of the interrupt pin is fixed per instance by a parameter.

Top module: `ppt_port`

## Requirements
- R1: After an active-low reset, pd_oe is 0 (input mode), pd_o is 0, ctl_o is 0, the interrupt is inactive (irq_o equals IRQ_ACTIVE_LOW), and the control register at address 2 reads 0x20.
- R2: A write to address 0 latches wdata at the first clock edge where wr_n is sampled low after being high. pd_o shows the value from that edge on and holds it.
- R3: A read of address 0 returns the data latch while pd_oe is 1. It returns the pd_i pins while pd_oe is 0.
- R4: The control register at address 2 holds ctl_o in bits 3:0, the interrupt enable in bit 4 and input mode in bit 5 (1 = input, pd_oe = 0). It reads back with bits 7:6 as zero.
- R5: A write to address 3 of 0xAA selects output mode and a write of 0x55 selects input mode. Any other value leaves the direction unchanged. Address 3 reads {7'b0, input-mode bit}, and the same bit appears in control bit 5.
- R6: Address 1 reads status as bit7 st_busy, bit6 st_ack_n, bit5 st_paper, bit4 st_sel, bit3 st_fault_n, bit2 interrupt pending, with bits 1:0 zero. Writes to address 1 have no effect.
- R7: rd_active is 1 exactly while rd_n is 0.
- R8: While the interrupt enable is 1, a falling edge of st_ack_n (sampled by the clock) sets the pending bit. irq_o equals pending XOR IRQ_ACTIVE_LOW.
- R9: The pending bit clears at the clock edge that sees rd_n return high at the end of a read of address 1. If an acknowledge fall arrives in the same cycle, the set wins.
- R10: With the interrupt enable at 0, acknowledge falls do not set the pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | 2 | Register address |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| wdata | input | 8 | CPU write data |
| rdata | output | 8 | CPU read data |
| rd_active | output | 1 | High while a read is in progress |
| pd_i | input | 8 | Sampled port bus |
| pd_o | output | 8 | Port bus drive value |
| pd_oe | output | 1 | Port bus output enable |
| ctl_o | output | 4 | Device control outputs |
| st_busy | input | 1 | Device busy status |
| st_ack_n | input | 1 | Device acknowledge, active low |
| st_paper | input | 1 | Paper-empty / general input |
| st_sel | input | 1 | Device selected status |
| st_fault_n | input | 1 | Device fault, active low |
| irq_o | output | 1 | Interrupt, polarity by parameter |

## Verification
The interrupt set from an acknowledge fall and the clear at the end of a status read can land on the same clock edge. The bench provokes this by releasing rd_n on the same half-cycle in which it drops st_ack_n, so one edge sees both events. It then judges the outcome by expecting irq_o still active and the pending bit still set on the next status read. A second case lets the clear act alone and expects irq_o to return to its inactive level.

// File: rtl/ppt_port.sv
module ppt_port #(
  parameter int          DW             = 8,
  parameter bit          IRQ_ACTIVE_LOW = 1'b0,
  parameter logic [DW-1:0] OUT_PAT      = 8'hAA,
  parameter logic [DW-1:0] IN_PAT       = 8'h55
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    addr,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rd_active,
  input  logic [DW-1:0] pd_i,
  output logic [DW-1:0] pd_o,
  output logic          pd_oe,
  output logic [3:0]    ctl_o,
  input  logic          st_busy,
  input  logic          st_ack_n,
  input  logic          st_paper,
  input  logic          st_sel,
  input  logic          st_fault_n,
  output logic          irq_o
);
  logic          wr_q, rd_q, ack_q;
  logic          dir_in, irq_en, pend;
  logic [3:0]    ctl;
  logic [DW-1:0] dlat;

  wire wr_go    = wr_q & ~wr_n;
  wire rd_end   = ~rd_q & rd_n;
  wire ack_fall = ack_q & ~st_ack_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b1;
      rd_q   <= 1'b1;
      ack_q  <= 1'b1;
      dir_in <= 1'b1;
      irq_en <= 1'b0;
      pend   <= 1'b0;
      ctl    <= '0;
      dlat   <= '0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      ack_q <= st_ack_n;
      if (wr_go) begin
        case (addr)
          2'd0: dlat <= wdata;
          2'd2: begin
            ctl    <= wdata[3:0];
            irq_en <= wdata[4];
            dir_in <= wdata[5];
          end
          2'd3: begin
            if (wdata == OUT_PAT)     dir_in <= 1'b0;
            else if (wdata == IN_PAT) dir_in <= 1'b1;
          end
          default: ;
        endcase
      end
      if (irq_en && ack_fall)          pend <= 1'b1;
      else if (rd_end && addr == 2'd1) pend <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      2'd0: rdata = dir_in ? pd_i : dlat;
      2'd1: rdata[7:0] = {st_busy, st_ack_n, st_paper, st_sel, st_fault_n, pend, 2'b00};
      2'd2: rdata[7:0] = {2'b00, dir_in, irq_en, ctl};
      default: rdata[0] = dir_in;
    endcase
  end

  assign rd_active = ~rd_n;
  assign pd_o      = dlat;
  assign pd_oe     = ~dir_in;
  assign ctl_o     = ctl;
  assign irq_o     = pend ^ IRQ_ACTIVE_LOW;
endmodule

module ppt_port_chk #(
  parameter int DW = 8,
  parameter bit IRQ_ACTIVE_LOW = 1'b0
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    addr,
  input logic          rd_n,
  input logic          wr_n,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic [DW-1:0] pd_i,
  input logic [DW-1:0] pd_o,
  input logic          pd_oe,
  input logic          st_ack_n,
  input logic          irq_o,
  input logic          wr_q,
  input logic          rd_q,
  input logic          ack_q
);
  // R2
  data_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_q && !wr_n && addr == 2'd0) |=> (pd_o == $past(wdata)));
  // R3
  input_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && addr == 2'd0 && !pd_oe) |-> (rdata == pd_i));
  // R5
  pat_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_q && !wr_n && addr == 2'd3 && wdata == 8'hAA) |=> pd_oe);
  // R5
  pat_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_q && !wr_n && addr == 2'd3 && wdata != 8'hAA && wdata != 8'h55) |=> $stable(pd_oe));
  // R9
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_q && rd_n && addr == 2'd1 && !(ack_q && !st_ack_n)) |=> (irq_o == IRQ_ACTIVE_LOW));
endmodule

bind ppt_port ppt_port_chk #(.DW(DW), .IRQ_ACTIVE_LOW(IRQ_ACTIVE_LOW)) i_ppt_port_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd_n(rd_n), .wr_n(wr_n), .wdata(wdata),
  .rdata(rdata), .pd_i(pd_i), .pd_o(pd_o), .pd_oe(pd_oe), .st_ack_n(st_ack_n),
  .irq_o(irq_o), .wr_q(wr_q), .rd_q(rd_q), .ack_q(ack_q));

// File: tb/test_ppt_port.sv
module test_ppt_port;
  localparam bit ACT_LOW = 1'b1;
  logic clk = 0, rst_n = 0;
  logic [1:0] addr = 0;
  logic rd_n = 1, wr_n = 1;
  logic [7:0] wdata = 0, pd_i = 0;
  logic st_busy = 0, st_ack_n = 1, st_paper = 0, st_sel = 0, st_fault_n = 1;
  logic [7:0] rdata, pd_o;
  logic rd_active, pd_oe, irq_o;
  logic [3:0] ctl_o;
  int checks = 0, errors = 0;
  logic m_dir, m_en;
  logic [7:0] m_lat, v;

  always #2.5 clk = ~clk;

  ppt_port #(.IRQ_ACTIVE_LOW(ACT_LOW)) i_ppt_port (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] stat_exp(input logic p);
    return {st_busy, st_ack_n, st_paper, st_sel, st_fault_n, p, 2'b00};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_n = 0;
    @(negedge clk); wr_n = 1;
    @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_n = 0;
    #1 d = rdata;
    check(rd_active == 1'b1, "R7", rd_active, 1);
    @(negedge clk); rd_n = 1;
    #1 check(rd_active == 1'b0, "R7", rd_active, 0);
    @(negedge clk);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    check(pd_oe == 0, "R1", pd_oe, 0);
    check(pd_o == 0, "R1", pd_o, 0);
    check(ctl_o == 0, "R1", ctl_o, 0);
    check(irq_o == ACT_LOW, "R1", irq_o, ACT_LOW);
    rst_n = 1;
    rd(2, v); check(v == 8'h20, "R1", v, 8'h20);
    m_dir = 1; m_en = 0; m_lat = 0;

    wr(2, 8'h0B); m_dir = 0;
    check(ctl_o == 4'hB && pd_oe == 1, "R4", {ctl_o, 3'b0, pd_oe}, 8'hB1);
    rd(2, v); check(v == 8'h0B, "R4", v, 8'h0B);

    for (int i = 0; i < 40; i++) begin
      logic [7:0] d, p;
      d = 8'($urandom); p = 8'($urandom);
      case ($urandom % 3)
        0: begin
          wr(0, d); m_lat = d;
          check(pd_o == d, "R2", pd_o, d);
        end
        1: begin
          pd_i = p;
          rd(0, v);
          check(v == (m_dir ? p : m_lat), "R3", v, m_dir ? p : m_lat);
        end
        default: begin
          if (i % 4 == 0) d = 8'hAA; else if (i % 4 == 1) d = 8'h55;
          wr(3, d);
          if (d == 8'hAA) m_dir = 0; else if (d == 8'h55) m_dir = 1;
          check(pd_oe == !m_dir, "R5", pd_oe, !m_dir);
          rd(3, v); check(v == {7'b0, m_dir}, "R5", v, m_dir);
        end
      endcase
    end

    wr(3, 8'hAA); wr(3, 8'h12);
    check(pd_oe == 1, "R5", pd_oe, 1);
    wr(3, 8'h55); wr(3, 8'hAB);
    check(pd_oe == 0, "R5", pd_oe, 0);
    rd(2, v); check(v[5] == 1, "R5", v, 1);

    st_busy = 1; st_paper = 1; st_sel = 0; st_fault_n = 0;
    wr(1, 8'hFF);
    rd(1, v); check(v == stat_exp(0), "R6", v, stat_exp(0));
    st_paper = 0; st_sel = 1;
    rd(1, v); check(v == stat_exp(0), "R6", v, stat_exp(0));

    @(negedge clk); st_ack_n = 0; @(negedge clk); @(negedge clk); st_ack_n = 1;
    @(negedge clk);
    check(irq_o == ACT_LOW, "R10", irq_o, ACT_LOW);
    rd(1, v); check(v[2] == 0, "R10", v, 0);

    wr(2, 8'h10);
    @(negedge clk); st_ack_n = 0; @(negedge clk); st_ack_n = 1; @(negedge clk);
    check(irq_o == !ACT_LOW, "R8", irq_o, !ACT_LOW);
    check(stat_exp(1) == rdata || addr != 1, "R8", 0, 0);
    rd(1, v); check(v[2] == 1, "R8", v, 1);
    check(irq_o == ACT_LOW, "R9", irq_o, ACT_LOW);

    @(negedge clk); st_ack_n = 0; @(negedge clk); st_ack_n = 1; @(negedge clk);
    @(negedge clk); addr = 1; rd_n = 0;
    @(negedge clk); rd_n = 1; st_ack_n = 0;
    @(negedge clk); st_ack_n = 1;
    @(negedge clk);
    check(irq_o == !ACT_LOW, "R9", irq_o, !ACT_LOW);
    rd(1, v); check(v[2] == 1, "R9", v, 1);
    check(irq_o == ACT_LOW, "R9", irq_o, ACT_LOW);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule